// File: doc/BRIEF.md
# Bitfield Extract Unit

This block is the execution slice of a 64-bit integer core that pulls a contiguous bit field out of a source operand. It accepts one 32-bit instruction word together with the 64-bit source value, works out from the instruction which of four extract forms is wanted, and returns the chosen field shifted down to bit 0. Three forms cover 64-bit fields and return them with zero fill above the field. The fourth form works on the low word and sign-extends its 32-bit result from bit 31.

Each instruction carries only two 5-bit fields, one for the field width and one for its starting bit. To reach every field of a 64-bit operand, each form adds a bias of 32 to one of these two fields, or to neither. The unit turns the two fields into a true start bit and a true width of 1 to 64, checks that the field lies inside the operand, and builds the mask bit by bit. A 64-bit-wide field is therefore no special case for the shifter. The result is registered one clock after the input strobe, together with a valid flag and a flag that marks an encoding the unit refuses to execute.

Top module: `bitfield_extract_unit`

## Requirements
- R1: The major opcode is instruction bits [31:26] and must equal 6'h1F. Any other value makes the operation illegal. The width code sits in bits [15:11], the start code in bits [10:6], the function code in bits [5:0], and bits [25:16] are ignored.
- R2: Function codes 0, 1, 2 and 3 select the word, middle, upper and double forms. Function codes 4 to 63 are illegal.
- R3: Double form (function 3): width = width code + 1 and start = start code. The result is the field, right-justified, with zeros above it.
- R4: Middle form (function 1): width = width code + 33, which gives widths 33 to 64, and start = start code. The result is zero-extended.
- R5: Upper form (function 2): start = start code + 32 and width = width code + 1. The result is zero-extended, even when the field's top bit is set.
- R6: A width of 64 returns the whole source operand unchanged.
- R7: Word form (function 0): width = width code + 1 and start = start code. The 32-bit field result is sign-extended from bit 31 into bits [63:32].
- R8: The operation is illegal if start + width exceeds 64, or exceeds 32 for the word form.
- R9: For an illegal operation, illegal is 1 and result is 0 in the cycle in which out_valid is 1.
- R10: out_valid is 1 exactly in the cycle after a clock edge that sampled in_valid high. When no operation is accepted, result keeps its value and illegal is 0.
- R11: A synchronous active-low reset clears out_valid, illegal and result, and it overrides an input presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| instr | input | 32 | Instruction word |
| src | input | 64 | Source operand |
| out_valid | output | 1 | Result register holds a new operation |
| result | output | 64 | Extracted field |
| illegal | output | 1 | The operation was refused; result is zero |

## Verification
The bench goes after the bias of each form. A middle form that forgot its +33 would return a field 32 bits short, and an upper form that forgot its +32 would return low-word bits. It checks the full-width field, where a mask built by shifting a one left 64 places would come out empty or all ones. It also checks the last legal field and the first illegal one of each form, where an off-by-one range test would either accept a field that runs off the operand or reject a valid one. For the word form it tests a field with bit 31 set, where a missing sign extension leaves the upper word zero, and narrow fields, where sign-extending from the field's own top bit instead of bit 31 would wrongly fill the upper word. Hold and reset-priority checks catch a result register that is overwritten while idle or that lets an input win over reset.

// File: rtl/bfx_pkg.sv
// Shared constants and types for the bitfield extract unit.
// Assumes a 64-bit datapath with 5-bit width and start codes.
package bfx_pkg;
    localparam int unsigned XLEN     = 64;
    localparam int unsigned HALF     = XLEN / 2;
    localparam int unsigned CODE_W   = $clog2(HALF);      // 5
    localparam int unsigned POS_W    = $clog2(XLEN);      // 6
    localparam int unsigned SIZE_W   = POS_W + 1;         // 7, holds 1..64
    localparam int unsigned EXTENT_W = SIZE_W + 1;        // start + width
    localparam logic [5:0]  MAJOR_OP = 6'h1F;

    typedef enum logic [5:0] {
        FN_WORD   = 6'd0,
        FN_MIDDLE = 6'd1,
        FN_UPPER  = 6'd2,
        FN_DOUBLE = 6'd3
    } bfx_fn_e;

    typedef struct packed {
        logic [POS_W-1:0]  start;
        logic [SIZE_W-1:0] width;
        logic              word_form;
        logic              bad;
    } bfx_op_t;
endpackage

// File: rtl/bfx_decode.sv
// Decoder: turns opcode, function, width and start codes into a real start
// bit and width, and flags illegal encodings and fields that overrun the
// operand. Assumes the codes are already sliced from the instruction.
module bfx_decode
    import bfx_pkg::*;
(
    input  logic [5:0]        opcode,
    input  logic [5:0]        func,
    input  logic [CODE_W-1:0] width_code,
    input  logic [CODE_W-1:0] start_code,
    output bfx_op_t           op
);
    logic [SIZE_W-1:0]   width_w;
    logic [POS_W-1:0]    start_w;
    logic [EXTENT_W-1:0] extent;
    logic                fn_ok;
    logic                word;

    // Apply the per-form bias to the width and start codes.
    always_comb begin
        width_w = SIZE_W'(width_code) + SIZE_W'(1);
        start_w = POS_W'(start_code);
        fn_ok   = 1'b1;
        word    = 1'b0;
        case (func)
            FN_WORD:   word    = 1'b1;
            FN_MIDDLE: width_w = SIZE_W'(width_code) + SIZE_W'(HALF + 1);
            FN_UPPER:  start_w = POS_W'(start_code) + POS_W'(HALF);
            FN_DOUBLE: ;
            default:   fn_ok   = 1'b0;
        endcase
    end

    // Range check of the field end against the operand or word boundary.
    always_comb begin
        extent    = EXTENT_W'(start_w) + EXTENT_W'(width_w);
        op.start  = start_w;
        op.width  = width_w;
        op.word_form = word;
        op.bad    = (opcode != MAJOR_OP) || !fn_ok
                 || (extent > EXTENT_W'(XLEN))
                 || (word && (extent > EXTENT_W'(HALF)));
    end
endmodule

// File: rtl/bfx_mask_gen.sv
// Mask generator: sets bit i when i is below the width. Each bit is a plain
// compare, so width 64 gives all ones with no 64-place shift.
// Assumes width is in 1..XLEN.
module bfx_mask_gen
    import bfx_pkg::*;
(
    input  logic [SIZE_W-1:0] width,
    output logic [XLEN-1:0]   mask
);
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        // One compare per mask bit.
        assign mask[i] = (SIZE_W'(i) < width);
    end
endmodule

// File: rtl/bfx_align.sv
// Aligner: shifts the source down by the start bit, keeps the masked field,
// and sign-extends from bit 31 for the word form.
module bfx_align
    import bfx_pkg::*;
(
    input  logic [XLEN-1:0]  src,
    input  logic [POS_W-1:0] start,
    input  logic [XLEN-1:0]  mask,
    input  logic             word_form,
    output logic [XLEN-1:0]  field
);
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] masked;

    // Right-justify and clip the field, then pick the extension rule.
    always_comb begin
        shifted = src >> start;
        masked  = shifted & mask;
        if (word_form)
            field = {{HALF{masked[HALF-1]}}, masked[HALF-1:0]};
        else
            field = masked;
    end
endmodule

// File: rtl/bitfield_extract_unit.sv
// Top of the bitfield extract unit: decode, mask, align, then one output
// register stage. Synchronous active-low reset. Assumes one operation per
// cycle with no back-pressure.
module bitfield_extract_unit
    import bfx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            illegal
);
    bfx_op_t         op;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] field;
    logic            unused_reg_fields;

    // Register selects are handled outside this unit.
    assign unused_reg_fields = ^instr[25:16];

    bfx_decode u_decode (
        .opcode     (instr[31:26]),
        .func       (instr[5:0]),
        .width_code (instr[15:11]),
        .start_code (instr[10:6]),
        .op         (op)
    );

    bfx_mask_gen u_mask (
        .width (op.width),
        .mask  (mask)
    );

    bfx_align u_align (
        .src       (src),
        .start     (op.start),
        .mask      (mask),
        .word_form (op.word_form),
        .field     (field)
    );

    // Output stage: capture an accepted operation, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            illegal   <= in_valid & op.bad;
            if (in_valid)
                result <= op.bad ? '0 : field;
        end
    end
endmodule

// File: rtl/bfx_checker.sv
// Checker bound to the top: port-level timing and encoding properties.
module bfx_checker
    import bfx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic            illegal
);
    // R10: out_valid follows in_valid by one clock.
    assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !illegal && $stable(result)));
    // R9: an illegal flag comes with a zero result in a valid cycle.
    assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (out_valid && result == '0));
    // R1: wrong major opcode is refused.
    assert_bad_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] != MAJOR_OP) |=> illegal);
    // R2: function codes above 3 are refused.
    assert_bad_func_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[5:0] > 6'd3) |=> illegal);
    // R7: word form upper half copies bit 31.
    assert_word_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[5:0] == 6'd0) |=> (illegal || result[63:32] == {32{result[31]}}));
    // R5: upper form fields are at most 32 bits, so the upper word stays zero.
    assert_upper_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[5:0] == 6'd2) |=> (result[63:32] == 32'h0));
    // R11: reset clears the outputs.
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !illegal && result == '0));
endmodule

bind bitfield_extract_unit bfx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .out_valid (out_valid),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/sim_bitfield_extract_unit.sv
module sim_bitfield_extract_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    bitfield_extract_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src(src), .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [63:0] op;
        logic [63:0] exp;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam logic [63:0] SA = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] SB = 64'h0123_4567_89AB_CDEF;
    localparam vec_t VECS [NV] = '{
        '{32'h7CA4_3903, SA, 64'h21, 1'b0, 8'd3},                  // R3 start 4 width 8
        '{32'h7CA4_F803, SA, 64'h7654_3210, 1'b0, 8'd3},           // R3 width 32
        '{32'h7CA4_FFC3, SA, 64'hFDB9_7530, 1'b0, 8'd3},           // R3 ends at bit 62
        '{32'h7CA4_F801, SA, SA, 1'b0, 8'd6},                      // R6 middle width 64
        '{32'h7CA4_07C1, SA, 64'h1_FDB9_7530, 1'b0, 8'd4},         // R4 start 31 width 33
        '{32'h7CA4_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_FFFF_FFFF, 1'b0, 8'd4}, // R4 width 33
        '{32'h7CA4_0002, 64'hA5A5_A5A5_0000_0000, 64'h1, 1'b0, 8'd5}, // R5 bit 32
        '{32'h7CA4_07C2, SA, 64'h1, 1'b0, 8'd5},                   // R5 bit 63
        '{32'h7CA4_F802, SA, 64'hFEDC_BA98, 1'b0, 8'd5},           // R5 no sign fill
        '{32'h7CA4_F800, SB, 64'hFFFF_FFFF_89AB_CDEF, 1'b0, 8'd7}, // R7 sign fill
        '{32'h7CA4_3900, SB, 64'hDE, 1'b0, 8'd7},                  // R7 narrow field
        '{32'h7CA4_07C0, SB, 64'h1, 1'b0, 8'd7},                   // R7 bit 31 alone
        '{32'h7CA4_F900, SB, 64'h0, 1'b1, 8'd8},                   // R8 word overrun
        '{32'h7CA4_F841, SA, 64'h0, 1'b1, 8'd8},                   // R8 middle 1+64
        '{32'h7CA4_FFC1, SA, 64'h0, 1'b1, 8'd8},                   // R8 middle 31+64
        '{32'h7CA4_F842, SA, 64'h0, 1'b1, 8'd8},                   // R8 upper 33+32
        '{32'h7CA4_3904, SA, 64'h0, 1'b1, 8'd2},                   // R2 function 4
        '{32'h00A4_3903, SA, 64'h0, 1'b1, 8'd1},                   // R1 wrong opcode
        '{32'h7C00_3903, SA, 64'h21, 1'b0, 8'd1}                   // R1 reg fields ignored
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] ins, input logic [63:0] op);
        @(negedge clk);
        in_valid = 1'b1; instr = ins; src = op;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 out_valid at reset", 64'(out_valid), 64'h0);
        check("R11 result at reset", result, 64'h0);
        check("R11 illegal at reset", 64'(illegal), 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].ins, VECS[i].op);
            check($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].exp);
            check($sformatf("R%0d vec %0d illegal", VECS[i].req, i), 64'(illegal), 64'(VECS[i].ill));
            check($sformatf("R10 vec %0d out_valid", i), 64'(out_valid), 64'h1);
            if (VECS[i].ill) check($sformatf("R9 vec %0d zero", i), result, 64'h0);
        end

        // R10: idle cycle holds result, drops valid and illegal
        issue(32'h7CA4_3903, SA);
        @(negedge clk);
        check("R10 idle out_valid", 64'(out_valid), 64'h0);
        check("R10 idle hold", result, 64'h21);
        issue(32'h7CA4_3904, SA);
        @(negedge clk);
        check("R10 illegal drops when idle", 64'(illegal), 64'h0);

        // R11: reset wins over a presented input
        issue(32'h7CA4_F801, SA);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; instr = 32'h7CA4_F801; src = SA;
        @(negedge clk);
        check("R11 reset over input valid", 64'(out_valid), 64'h0);
        check("R11 reset over input result", result, 64'h0);
        in_valid = 1'b0; rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule